// File: doc/BRIEF.md
# Emulated PHY Auto-Negotiation Resolver

This block stands in for the negotiating half of a PHY that sits between a host MAC and an internal switch port. The switch side is treated as a virtual link partner that always offers every speed and duplex combination. Software sees a small set of management registers: control, status, local advertisement, partner ability and expansion. It reaches them over a parallel register bus with a write strobe and a read strobe.

When negotiation runs, the block ANDs the local advertisement with the partner's offer and picks the best mode they share. If they share none, it falls back to an emulated parallel detect that settles on 100 Mbps half duplex. With negotiation switched off, software forces the speed and duplex directly through the control register. The resolved mode leaves the block on two registered outputs, `speed_100` and `full_duplex`.

Top module: `autoneg_emu`

## Requirements
- R1: After reset is released, negotiation runs once by itself. One clock edge after release, the advertisement reads 0x01E1 and the outputs show 100 Mbps full duplex. While reset is held, both outputs are 0.
- R2: The resolved mode is the highest shared ability in the order 100 full, 100 half, 10 full, 10 half. Advertisement bits 8, 7, 6 and 5 stand for 100 full, 100 half, 10 full and 10 half, and bits 4:0 read as 00001.
- R3: When a result is latched, status bit 5 (complete) and expansion bit 1 (page received) are set. Status bit 3 always reads 1. A complete status reads 0x0028.
- R4: When a mode is shared, expansion bit 0 (partner able) is set, so the expansion register reads 0x0003. The partner ability register (address 5) then reads 0x01E1.
- R5: When no mode is shared, the result is 100 Mbps half duplex and expansion bit 0 is clear, so the expansion register reads 0x0002. The partner ability register then shows only bit 7 and reads 0x0081.
- R6: A write to the advertisement register (address 4) changes neither the outputs nor the partner and expansion registers until negotiation runs again.
- R7: Writing the control register (address 0) with bit 12 clear disables negotiation. One edge later, speed_100 equals written bit 13 and full_duplex equals written bit 8. Status then reads 0x0008, and the expansion and partner registers read 0. Writing bit 12 set while negotiation is disabled starts a new negotiation.
- R8: While negotiation is enabled, a control write with bit 12 set and bit 9 clear changes neither the outputs nor the status. Bits 13 and 8 are stored and read back.
- R9: A control write with bits 12 and 9 set restarts negotiation. Complete, page received and partner able read 0 in the cycle after the write, and control bit 9 reads 1 there. The new result is latched one edge later, after which bit 9 reads 0.
- R10: Read data is registered and appears one cycle after the read strobe. Addresses other than 0, 1, 4, 5 and 6 read as 0.
- R11: speed_100 and full_duplex change only when a negotiation result is latched or a forced-mode write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| speed_100 | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_duplex | output | 1 | 1 = full duplex, 0 = half duplex |

## Verification
The resolver is driven with random 4-bit advertisements. Some of these share exactly one mode with the partner, and some share several, which separates a correct priority order from a merely any-match rule. Directed cases cover the empty advertisement, which selects the parallel-detect branch and its single reported partner bit. Advertisement writes with no restart after them show that a stored value is not consumed early.

Forced-mode writes with random speed and duplex are mixed with re-enables. Writes of bits 13 and 8 while negotiation is enabled are checked to be ignored. A read straight after a restart catches designs that clear the status flags late or latch the result early.

// File: rtl/autoneg_pkg.sv
package autoneg_pkg;
  localparam int NUM_ABIL = 4;
  localparam int ABIL_LSB = 5;
  localparam int SEL_W    = 5;
  localparam logic [SEL_W-1:0] SELECTOR = 5'b00001;

  // ability vector index
  localparam int IX_10HD  = 0;
  localparam int IX_10FD  = 1;
  localparam int IX_100HD = 2;
  localparam int IX_100FD = 3;

  // control bits
  localparam int CB_SPEED   = 13;
  localparam int CB_ANEN    = 12;
  localparam int CB_RESTART = 9;
  localparam int CB_DUPLEX  = 8;
  // status and expansion bits
  localparam int SB_COMPLETE = 5;
  localparam int SB_ABLE     = 3;
  localparam int EB_PAGE     = 1;
  localparam int EB_LPABLE   = 0;

  // register addresses
  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_ADV  = 4;
  localparam int RA_LPA  = 5;
  localparam int RA_EXP  = 6;

  typedef struct packed {
    logic complete;
    logic page_rx;
    logic lp_able;
  } neg_flags_t;
endpackage

// File: rtl/autoneg_hcd.sv
module autoneg_hcd
  import autoneg_pkg::*;
#(
  parameter logic [NUM_ABIL-1:0] PARTNER = '1
) (
  input  logic [NUM_ABIL-1:0] adv,
  output logic                match,
  output logic [NUM_ABIL-1:0] lp_report,
  output logic                res_spd,
  output logic                res_dup
);
  logic [NUM_ABIL-1:0] common;
  logic [NUM_ABIL-1:0] above;
  logic [NUM_ABIL-1:0] win;
  logic [NUM_ABIL-1:0] pick;

  assign common = adv & PARTNER;

  generate
    for (genvar i = 0; i < NUM_ABIL; i++) begin : g_pri
      if (i == NUM_ABIL - 1) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_low
        assign above[i] = |common[NUM_ABIL-1:i+1];
      end
      assign win[i] = common[i] & ~above[i];
    end
  endgenerate

  assign match     = |common;
  assign pick      = match ? win : NUM_ABIL'(1 << IX_100HD);
  assign lp_report = match ? PARTNER : pick;
  assign res_spd   = pick[IX_100FD] | pick[IX_100HD];
  assign res_dup   = pick[IX_100FD] | pick[IX_10FD];

  // R2: exactly one mode is chosen
  always_comb begin
    p_onehot_pick_r2: assert ($onehot(pick));
  end
endmodule

// File: rtl/autoneg_seq.sv
module autoneg_seq
  import autoneg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic                force_req,
  input  logic                force_spd,
  input  logic                force_dup,
  input  logic                match,
  input  logic                res_spd,
  input  logic                res_dup,
  input  logic [NUM_ABIL-1:0] lp_report,
  output logic                busy,
  output neg_flags_t          flags,
  output logic [NUM_ABIL-1:0] lp_abil,
  output logic                speed_100,
  output logic                full_duplex
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b1;
      flags       <= '0;
      lp_abil     <= '0;
      speed_100   <= 1'b0;
      full_duplex <= 1'b0;
    end else if (force_req) begin
      busy        <= 1'b0;
      flags       <= '0;
      lp_abil     <= '0;
      speed_100   <= force_spd;
      full_duplex <= force_dup;
    end else if (start_req) begin
      busy    <= 1'b1;
      flags   <= '0;
      lp_abil <= '0;
    end else if (busy) begin
      busy             <= 1'b0;
      flags.complete   <= 1'b1;
      flags.page_rx    <= 1'b1;
      flags.lp_able    <= match;
      lp_abil          <= lp_report;
      speed_100        <= res_spd;
      full_duplex      <= res_dup;
    end
  end

  // R9: a restart empties the flags on the next edge
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (start_req && !force_req) |=> (busy && !flags.complete && !flags.page_rx && !flags.lp_able));

  // R3: a pending run latches completion on the next edge
  p_latch_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_req && !force_req) |=> (flags.complete && flags.page_rx && !busy));

  // R7: forced mode copies the written bits
  p_force_follows_r7: assert property (@(posedge clk) disable iff (rst)
    force_req |=> (speed_100 == $past(force_spd) && full_duplex == $past(force_dup) && lp_abil == '0));

  // R11: outputs hold unless a result or a force lands
  p_out_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !force_req) |=> ($stable(speed_100) && $stable(full_duplex)));
endmodule

// File: rtl/autoneg_regbus.sv
module autoneg_regbus
  import autoneg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                busy,
  input  neg_flags_t          flags,
  input  logic [NUM_ABIL-1:0] lp_abil,
  output logic [NUM_ABIL-1:0] adv,
  output logic                start_req,
  output logic                force_req,
  output logic                ctl_spd,
  output logic                ctl_dup
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);
  localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(RA_ADV);
  localparam logic [ADDR_W-1:0] A_LPA  = ADDR_W'(RA_LPA);
  localparam logic [ADDR_W-1:0] A_EXP  = ADDR_W'(RA_EXP);

  logic              ctl_en;
  logic              wr_ctrl;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign start_req = wr_ctrl && wdata[CB_ANEN] && (wdata[CB_RESTART] || !ctl_en);
  assign force_req = wr_ctrl && !wdata[CB_ANEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en  <= 1'b1;
      ctl_spd <= 1'b1;
      ctl_dup <= 1'b1;
      adv     <= '1;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        ctl_en  <= wdata[CB_ANEN];
        ctl_spd <= wdata[CB_SPEED];
        ctl_dup <= wdata[CB_DUPLEX];
      end
      if (addr == A_ADV) adv <= wdata[ABIL_LSB +: NUM_ABIL];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[CB_ANEN]    = ctl_en;
        rd_mux[CB_SPEED]   = ctl_spd;
        rd_mux[CB_DUPLEX]  = ctl_dup;
        rd_mux[CB_RESTART] = busy;
      end
      A_STAT: begin
        rd_mux[SB_COMPLETE] = flags.complete;
        rd_mux[SB_ABLE]     = 1'b1;
      end
      A_ADV: begin
        rd_mux[SEL_W-1:0]            = SELECTOR;
        rd_mux[ABIL_LSB +: NUM_ABIL] = adv;
      end
      A_LPA: begin
        if (|lp_abil) rd_mux[SEL_W-1:0] = SELECTOR;
        rd_mux[ABIL_LSB +: NUM_ABIL] = lp_abil;
      end
      A_EXP: begin
        rd_mux[EB_PAGE]   = flags.page_rx;
        rd_mux[EB_LPABLE] = flags.lp_able;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10: unmapped addresses return zero one cycle later
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != A_CTRL && addr != A_STAT && addr != A_ADV && addr != A_LPA && addr != A_EXP)
    |=> (rdata == '0));

  // R7: with negotiation off, the partner register reads zero
  p_off_no_partner_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_LPA && !ctl_en) |=> (rdata == '0));
endmodule

// File: rtl/autoneg_emu.sv
module autoneg_emu
  import autoneg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [NUM_ABIL-1:0] PARTNER = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              speed_100,
  output logic              full_duplex
);
  logic                busy;
  neg_flags_t          flags;
  logic [NUM_ABIL-1:0] lp_abil;
  logic [NUM_ABIL-1:0] adv;
  logic [NUM_ABIL-1:0] lp_report;
  logic                start_req, force_req, ctl_spd, ctl_dup;
  logic                match, res_spd, res_dup;

  autoneg_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .flags(flags),
    .lp_abil(lp_abil), .adv(adv), .start_req(start_req), .force_req(force_req),
    .ctl_spd(ctl_spd), .ctl_dup(ctl_dup)
  );

  autoneg_hcd #(.PARTNER(PARTNER)) u_hcd (
    .adv(adv), .match(match), .lp_report(lp_report),
    .res_spd(res_spd), .res_dup(res_dup)
  );

  autoneg_seq u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .force_req(force_req),
    .force_spd(ctl_spd_next), .force_dup(ctl_dup_next), .match(match),
    .res_spd(res_spd), .res_dup(res_dup), .lp_report(lp_report),
    .busy(busy), .flags(flags), .lp_abil(lp_abil),
    .speed_100(speed_100), .full_duplex(full_duplex)
  );

  logic ctl_spd_next, ctl_dup_next;
  logic unused_ctl;
  assign ctl_spd_next = reg_wdata[CB_SPEED];
  assign ctl_dup_next = reg_wdata[CB_DUPLEX];
  assign unused_ctl   = ctl_spd ^ ctl_dup;
endmodule

// File: tb/tb_autoneg_emu.sv
module tb_autoneg_emu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        speed_100, full_duplex;

  int errors = 0, checks = 0;
  logic cur_spd, cur_dup;
  logic [3:0] cur_adv;
  logic [15:0] d;

  always #10 clk = ~clk;

  autoneg_emu dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .speed_100(speed_100), .full_duplex(full_duplex)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // both tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  function automatic logic [15:0] ctrlw(input logic en, input logic s, input logic du, input logic rs);
    ctrlw = 16'(en) << 12 | 16'(s) << 13 | 16'(du) << 8 | 16'(rs) << 9;
  endfunction

  // expected {speed, duplex} from priority order
  function automatic logic [1:0] exp_mode(input logic [3:0] a);
    if (a[3]) exp_mode = 2'b11;
    else if (a[2]) exp_mode = 2'b10;
    else if (a[1]) exp_mode = 2'b01;
    else if (a[0]) exp_mode = 2'b00;
    else exp_mode = 2'b10;
  endfunction

  function automatic logic [15:0] exp_lpa(input logic [3:0] a);
    exp_lpa = (a != 0) ? 16'h01E1 : 16'h0081;
  endfunction

  function automatic logic [15:0] exp_exp(input logic [3:0] a);
    exp_exp = (a != 0) ? 16'h0003 : 16'h0002;
  endfunction

  task automatic check_result(input string tag);
    logic [1:0] m;
    logic [15:0] v;
    m = exp_mode(cur_adv);
    chk({tag, " speed"}, speed_100, m[1]);
    chk({tag, " duplex"}, full_duplex, m[0]);
    rd(5'd6, v); chk("R4 R5 expansion", v, exp_exp(cur_adv));
    rd(5'd5, v); chk("R4 R5 partner", v, exp_lpa(cur_adv));
    rd(5'd1, v); chk("R3 status", v, 16'h0028);
    cur_spd = m[1]; cur_dup = m[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R1 reset speed", speed_100, 1'b0);
    chk("R1 reset duplex", full_duplex, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    cur_adv = 4'hF;
    chk("R1 auto speed", speed_100, 1'b1);
    chk("R1 auto duplex", full_duplex, 1'b1);
    rd(5'd4, d); chk("R1 adv reset", d, 16'h01E1);
    check_result("R1");

    // R10 unmapped reads
    rd(5'd3, d);  chk("R10 unmapped 3", d, 16'h0000);
    rd(5'd31, d); chk("R10 unmapped 31", d, 16'h0000);

    // R5 empty advertisement, R9 pending read
    wr(5'd4, 16'h0001);
    chk("R6 speed held", speed_100, cur_spd);
    chk("R6 duplex held", full_duplex, cur_dup);
    rd(5'd5, d); chk("R6 partner held", d, 16'h01E1);
    cur_adv = 4'h0;
    wr(5'd0, ctrlw(1, 0, 0, 1));
    rd(5'd0, d); chk("R9 restart pending", d, 16'h1200);
    check_result("R5");
    rd(5'd0, d); chk("R9 self clear", d, 16'h1000);

    // R8 bits 13 and 8 ignored while enabled
    wr(5'd0, ctrlw(1, 0, 1, 0));
    @(negedge clk);
    chk("R8 speed held", speed_100, cur_spd);
    chk("R8 duplex held", full_duplex, cur_dup);
    rd(5'd1, d); chk("R8 status held", d, 16'h0028);
    rd(5'd0, d); chk("R8 ctrl readback", d, 16'h1100);

    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 0) begin
        logic s, du;
        s = 1'($urandom); du = 1'($urandom);
        wr(5'd0, ctrlw(0, s, du, 0));
        chk("R7 forced speed", speed_100, s);
        chk("R7 forced duplex", full_duplex, du);
        rd(5'd5, d); chk("R7 partner zero", d, 16'h0000);
        rd(5'd6, d); chk("R7 expansion zero", d, 16'h0000);
        rd(5'd1, d); chk("R7 status", d, 16'h0008);
        wr(5'd0, ctrlw(1, 1'($urandom), 1'($urandom), 0));
        @(negedge clk);
        check_result("R7 re-enable");
      end else begin
        logic [3:0] a;
        a = 4'($urandom);
        if (i % 7 == 3) a = 4'h0;
        wr(5'd4, 16'(a) << 5 | 16'h0001);
        chk("R11 speed held", speed_100, cur_spd);
        chk("R11 duplex held", full_duplex, cur_dup);
        rd(5'd6, d); chk("R6 expansion held", d, exp_exp(cur_adv));
        cur_adv = a;
        wr(5'd0, ctrlw(1, 1'($urandom), 1'($urandom), 1));
        rd(5'd1, d); chk("R9 cleared status", d, 16'h0008);
        check_result("R2");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule